// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block watches the eight pins of one general-purpose port and turns pin activity into interrupt requests. Every pin has its own detection setting: it can react to a level or to an edge, and the polarity is selectable. In edge mode the pin can also react to both directions at once. Pin inputs are asynchronous, so the block brings them into the clock domain through a synchronizer chain before it examines them.

Software programs four configuration registers: sense, both-edges, polarity and mask. It reads a raw status word and a masked status word, and it acknowledges edge events through a write-one-to-clear register. An edge event stays latched until software clears it. A level event follows the pin directly. All masked status bits are ORed into one port interrupt line. One designated pin also produces a single-cycle trigger pulse that can start a converter or a timer elsewhere on the chip.

The register port is a plain single-cycle access port. A write takes effect at the next clock edge. Reads are combinational from the selected register. There is no streaming data path, so the port has no valid/ready handshake, and no access can be stalled.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the sense, both-edges, polarity and mask registers read 0, both status words read 0, and `irq_o` and `trig_o` are 0.
- R2: Sense register (select 0) bit i chooses edge detection (0) or level detection (1) for pin i.
- R3: Both-edges register (select 1) bit i set makes an edge-mode pin latch status on a rising or a falling edge, whatever its polarity bit says.
- R4: Polarity register (select 2) bit i = 1 means rising edge or high level, and = 0 means falling edge or low level.
- R5: Select 4 reads the raw status of every pin regardless of the mask. Select 5 reads raw status ANDed with the mask register (select 3). Select 6 and select 7 read 0.
- R6: `irq_o` is 1 exactly when some masked status bit is 1.
- R7: An edge status bit stays set until a write to select 6 has a 1 in that bit position. A 0 bit in that write leaves the status bit unchanged. A new edge in the same cycle as the clear wins.
- R8: A level-mode status bit equals the pin's active-level condition, and writing the clear register does not change it.
- R9: `trig_o` is a one-cycle pulse on every 0-to-1 transition of the masked status bit of pin TRIG_PIN (default 4).
- R10: Changing the configuration of an unmasked pin can raise the interrupt at once. For example, switching a pin to level mode while it sits at its active level sets its status and `irq_o` in the cycle after the write.
- R11: A pin change reaches level status after SYNC_STAGES clocks (default 2). It sets edge status one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous pin levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 3 | Register select for the read |
| rd_data_o | output | 8 | Read data of the selected register |
| irq_o | output | 1 | Combined port interrupt |
| trig_o | output | 1 | Trigger pulse of the designated pin |

## Verification
The assertions assume two things about the inputs. First, each pin holds a value for at least one clock after it has passed the synchronizer. Second, the write strobe and select are stable around the clock edge. The stimulus respects both: it changes pins and register accesses only just after the falling clock edge and holds them for whole cycles. Random phases mix pin toggles, configuration rewrites on unmasked pins and clears. This drives the spurious-interrupt and clear-versus-new-edge cases naturally, and a behavioural model follows every cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_SENSE  = 3'd0,
    SEL_BOTH   = 3'd1,
    SEL_EVENT  = 3'd2,
    SEL_MASK   = 3'd3,
    SEL_RAW    = 3'd4,
    SEL_MASKED = 3'd5,
    SEL_CLEAR  = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[k] <= '0;
        else         chain_q[k] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[k] <= '0;
        else         chain_q[k] <= chain_q[k-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [W-1:0]     wr_data_i,
  output logic [W-1:0]     sense_o,
  output logic [W-1:0]     both_o,
  output logic [W-1:0]     event_o,
  output logic [W-1:0]     mask_o,
  output logic [W-1:0]     clr_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_o <= '0;
      both_o  <= '0;
      event_o <= '0;
      mask_o  <= '0;
    end else if (wr_en_i) begin
      case (sel)
        SEL_SENSE: sense_o <= wr_data_i;
        SEL_BOTH:  both_o  <= wr_data_i;
        SEL_EVENT: event_o <= wr_data_i;
        SEL_MASK:  mask_o  <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_o = '0;
    if (wr_en_i && sel == SEL_CLEAR) clr_o = wr_data_i;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] event_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] est_q;
  logic [W-1:0] edge_hit;
  logic [W-1:0] lvl_hit;
  logic [W-1:0] set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= s_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      if (both_i[i])       edge_hit[i] = s_i[i] ^ prev_q[i];
      else if (event_i[i]) edge_hit[i] = s_i[i] & ~prev_q[i];
      else                 edge_hit[i] = ~s_i[i] & prev_q[i];
      lvl_hit[i] = event_i[i] ? s_i[i] : ~s_i[i];
      set[i]     = ~sense_i[i] & edge_hit[i];
      raw_o[i]   = sense_i[i] ? lvl_hit[i] : est_q[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        est_q[i] <= 1'b0;
      else if (set[i])    est_q[i] <= 1'b1;
      else if (clr_i[i])  est_q[i] <= 1'b0;
    end

    // R3 / R2: a latched edge always has a real input change behind it
    p_edge_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(est_q[i]) |-> $past(s_i[i] != prev_q[i]));

    // R7: clear with no new edge empties the bit
    p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set[i]) |=> !est_q[i]);

    // R7: without a clear the bit holds
    p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (est_q[i] && !clr_i[i]) |=> est_q[i]);
  end

  // R11: the edge reference is the synchronized value one clock earlier
  p_prev_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> prev_q == $past(s_i));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TRIG_PIN    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     pin_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [W-1:0]     rd_data_o,
  output logic             irq_o,
  output logic             trig_o
);
  logic [W-1:0] pin_s;
  logic [W-1:0] sense, both, evt, mask, clr;
  logic [W-1:0] raw, masked;
  logic         trig_prev_q;

  gpio_irq_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_s)
  );

  gpio_irq_cfg #(.W(W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .sense_o(sense), .both_o(both), .event_o(evt), .mask_o(mask), .clr_o(clr)
  );

  gpio_irq_detect #(.W(W)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .s_i(pin_s),
    .sense_i(sense), .both_i(both), .event_i(evt), .clr_i(clr),
    .raw_o(raw)
  );

  assign masked = raw & mask;
  assign irq_o  = |masked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_prev_q <= 1'b0;
    else         trig_prev_q <= masked[TRIG_PIN];
  end
  assign trig_o = masked[TRIG_PIN] & ~trig_prev_q;

  always_comb begin
    case (reg_sel_e'(rd_sel_i))
      SEL_SENSE:  rd_data_o = sense;
      SEL_BOTH:   rd_data_o = both;
      SEL_EVENT:  rd_data_o = evt;
      SEL_MASK:   rd_data_o = mask;
      SEL_RAW:    rd_data_o = raw;
      SEL_MASKED: rd_data_o = masked;
      default:    rd_data_o = '0;
    endcase
  end

  // R9: the trigger never lasts two cycles
  p_trig_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  // R6: an interrupt needs a raw cause on an unmasked pin
  p_irq_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((raw & mask) != '0) && (raw != '0));

  // R1: configuration starts cleared, so nothing is unmasked right after reset
  p_reset_mask_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> mask == '0);
endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
  localparam int W = 8;
  localparam int T = 4;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] pin = '0;
  logic wr_en = 0;
  logic [2:0] wr_sel = '0, rd_sel = 3'd4;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic irq, trig;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .irq_o(irq), .trig_o(trig)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [W-1:0] mq1, ms, mp, mest, msense, mboth, mev, mmask;
  bit mtp;

  function automatic logic [W-1:0] m_raw();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      r[i] = msense[i] ? (mev[i] ? ms[i] : !ms[i]) : mest[i];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq1 = '0; ms = '0; mp = '0; mest = '0;
      msense = '0; mboth = '0; mev = '0; mmask = '0; mtp = 0;
    end else begin
      logic [W-1:0] mm;
      mm = m_raw() & mmask;
      for (int i = 0; i < W; i++) begin
        bit e;
        if (mboth[i]) e = ms[i] != mp[i];
        else if (mev[i]) e = ms[i] && !mp[i];
        else e = !ms[i] && mp[i];
        if (!msense[i] && e) mest[i] = 1;
        else if (wr_en && wr_sel == 3'd6 && wr_data[i]) mest[i] = 0;
      end
      if (wr_en) begin
        if (wr_sel == 3'd0) msense = wr_data;
        if (wr_sel == 3'd1) mboth = wr_data;
        if (wr_sel == 3'd2) mev = wr_data;
        if (wr_sel == 3'd3) mmask = wr_data;
      end
      mtp = mm[T];
      mp = ms; ms = mq1; mq1 = pin;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [W-1:0] mr, mm, er;
      mr = m_raw(); mm = mr & mmask;
      case (rd_sel)
        3'd0: er = msense;
        3'd1: er = mboth;
        3'd2: er = mev;
        3'd3: er = mmask;
        3'd4: er = mr;
        3'd5: er = mm;
        default: er = '0;
      endcase
      check(rd_data === er, "R5 model read", 32'(rd_data), 32'(er));
      check(irq === (mm != 0), "R6 model irq", 32'(irq), 32'(mm != 0));
      check(trig === (mm[T] && !mtp), "R9 model trig", 32'(trig), 32'(mm[T] && !mtp));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] s, input logic [W-1:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    step(1);
    wr_en = 0;
  endtask

  task automatic rdbit(input logic [2:0] s, input logic [W-1:0] m, input logic [W-1:0] e, input string tag);
    rd_sel = s; #1;
    check((rd_data & m) === e, tag, 32'(rd_data & m), 32'(e));
    rd_sel = 3'd4;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int pulses;
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    for (int s = 0; s < 6; s++) rdbit(3'(s), 8'hFF, 8'h00, "R1 reset register");
    check(irq === 0 && trig === 0, "R1 reset outputs", 32'({irq, trig}), 0);

    wr(3'd3, 8'hFF);
    wr(3'd2, 8'h11);
    // R4 rising edge, R2 edge mode
    pin = 8'h01; step(4);
    rdbit(3'd4, 8'h01, 8'h01, "R4 R2 rising edge latched");
    check(irq === 1, "R6 irq on masked status", 32'(irq), 1);
    pin = 8'h00; step(4);
    rdbit(3'd4, 8'h01, 8'h01, "R7 sticky after input returns");
    wr(3'd6, 8'h00);
    rdbit(3'd4, 8'h01, 8'h01, "R7 zero clear has no effect");
    wr(3'd6, 8'h01);
    rdbit(3'd4, 8'h01, 8'h00, "R7 clear by one");
    check(irq === 0, "R6 irq drops", 32'(irq), 0);
    // R4 falling on pin 1
    pin = 8'h02; step(4);
    rdbit(3'd4, 8'h02, 8'h00, "R4 falling mode ignores rise");
    pin = 8'h00; step(4);
    rdbit(3'd4, 8'h02, 8'h02, "R4 falling edge latched");
    wr(3'd6, 8'h02);
    // R3 both edges on pin 2
    wr(3'd1, 8'h04);
    pin = 8'h04; step(4);
    rdbit(3'd4, 8'h04, 8'h04, "R3 rise with both edges");
    wr(3'd6, 8'h04);
    rdbit(3'd4, 8'h04, 8'h00, "R3 cleared");
    pin = 8'h00; step(4);
    rdbit(3'd4, 8'h04, 8'h04, "R3 fall with both edges");
    wr(3'd6, 8'h04);
    // R5 masking
    wr(3'd3, 8'h00);
    pin = 8'h02; step(4); pin = 8'h00; step(4);
    rdbit(3'd4, 8'h02, 8'h02, "R5 raw ignores mask");
    rdbit(3'd5, 8'h02, 8'h00, "R5 masked hides bit");
    check(irq === 0, "R6 masked pin gives no irq", 32'(irq), 0);
    wr(3'd3, 8'hFF);
    rdbit(3'd5, 8'h02, 8'h02, "R5 masked shows bit");
    wr(3'd6, 8'h02);
    // R8 level on pin 3, R11 latency
    wr(3'd2, 8'h19);
    wr(3'd0, 8'h08);
    rdbit(3'd4, 8'h08, 8'h00, "R8 low input inactive");
    pin = 8'h08; step(1);
    rdbit(3'd4, 8'h08, 8'h00, "R11 level not yet through sync");
    step(1);
    rdbit(3'd4, 8'h08, 8'h08, "R11 level after two clocks");
    wr(3'd6, 8'h08);
    rdbit(3'd4, 8'h08, 8'h08, "R8 clear does not affect level");
    pin = 8'h00; step(4);
    rdbit(3'd4, 8'h08, 8'h00, "R8 level follows input");
    pin = 8'h01; step(2);
    rdbit(3'd4, 8'h01, 8'h00, "R11 edge not yet latched");
    step(1);
    rdbit(3'd4, 8'h01, 8'h01, "R11 edge latched one clock later");
    wr(3'd6, 8'h01);
    pin = 8'h00; step(4);
    // R9 trigger pin
    pulses = 0;
    pin = 8'h10;
    for (int k = 0; k < 6; k++) begin step(1); if (trig) pulses++; end
    check(pulses == 1, "R9 single trigger pulse", 32'(pulses), 1);
    pin = 8'h00; step(4); wr(3'd6, 8'h10);
    wr(3'd3, 8'hEF);
    pulses = 0;
    pin = 8'h10;
    for (int k = 0; k < 6; k++) begin step(1); if (trig) pulses++; end
    check(pulses == 0, "R9 no trigger while masked", 32'(pulses), 0);
    pin = 8'h00; step(4); wr(3'd6, 8'h10); wr(3'd3, 8'hFF);
    // R10 spurious interrupt on config change
    rdbit(3'd4, 8'h20, 8'h00, "R10 pin 5 idle");
    check(irq === 0, "R10 no irq before change", 32'(irq), 0);
    wr(3'd0, 8'h28);
    rdbit(3'd4, 8'h20, 8'h20, "R10 status after sense change");
    check(irq === 1, "R10 irq after sense change", 32'(irq), 1);
    wr(3'd0, 8'h08);

    // random phase against the reference
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 3) == 0) pin = 8'($urandom);
      wr_en = ($urandom_range(0, 4) == 0);
      wr_sel = 3'($urandom_range(0, 6));
      wr_data = 8'($urandom);
      rd_sel = 3'($urandom_range(0, 7));
      step(1);
    end
    wr_en = 0;
    step(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule